// File: doc/BRIEF.md
# Memory-to-Memory Pipelined Instruction Sequencer

This block is a small processor with no register file. Each arithmetic instruction names up to three source words and one destination word directly in a shared memory. The operands are read from that memory, passed through a single fixed-latency multiply-add unit, and the result is written straight back. Program and data live in the same 128-word memory. The program starts at address 0, and data conventionally occupies the upper half.

A program counter fetches one 32-bit instruction per clock into a shift-register instruction pipeline. The first decode point issues the operand reads. The stage at which memory data arrives drives the multiply-add. The stage at index RD_LAT + MADD_DEPTH − 1 commits the write. There is no branching, stalling or hazard detection. Software must keep a producer and a consumer of the same address far enough apart, either by filling the gap with independent instructions or with nops.

While idle, the memory is loaded through a load port and inspected through a peek port. A start pulse runs the program until its end marker. Each committed write is also reported on a registered writeback port.

Top module: `mm_seq`

## Requirements
- R1: After reset, busy, done and wb_valid are all 0.
- R2: While busy is 0, a cycle with load_we high writes load_data to address load_addr. While busy is 0, peek_data shows the word at peek_addr RD_LAT clocks after the address is applied.
- R3: A start pulse while busy is 0 sets busy to 1 and clears done from the next clock. Fetching then begins at address 0 and advances one word per clock.
- R4: Instruction layout: opcode in bits 31:28, destination in 27:21, source A in 20:14, source B in 13:7 and source C in 6:0. Each 7-bit field addresses one of 128 memory words. Opcodes: 0 nop, 1 add, 2 sub, 3 mpy, 4 mpy_add, 15 end.
- R5: Data is signed Q16.16. Add gives A+B, sub gives A−B, mpy gives A·B and mpy_add gives A·B+C. Every operation is evaluated as a·x+b, where the product is truncated toward minus infinity after dropping 16 fraction bits. The sum saturates to 0x7FFFFFFF or 0x80000000.
- R6: Only opcodes 1 to 4 write memory. Opcode 0 and any other opcode change no memory word, whatever their destination field holds.
- R7: Fetching the end opcode stops the fetch. Words after it are never executed. Once the instructions already in flight have drained, busy falls and done rises.
- R8: There is no interlock. With NSTAGE = RD_LAT + MADD_DEPTH, a consumer placed NSTAGE slots after its producer still reads the old value, and one placed NSTAGE+1 slots after it reads the new value.
- R9: Each memory write made by the program appears one clock later on wb_valid, wb_addr and wb_data. No writeback appears outside a run.
- R10: A load attempted while busy is 1 is ignored.
- R11: Independent instructions issued back to back, one per clock, each complete with the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to run the program from address 0 |
| load_we | input | 1 | Memory write strobe while idle |
| load_addr | input | 7 | Memory write address |
| load_data | input | 32 | Memory write data |
| peek_addr | input | 7 | Memory inspection address while idle |
| peek_data | output | 32 | Word at peek_addr, RD_LAT clocks later |
| busy | output | 1 | Program running or draining |
| done | output | 1 | Program finished; held until the next start |
| wb_valid | output | 1 | A result was written in the previous clock |
| wb_addr | output | 7 | Destination of that write |
| wb_data | output | 32 | Value of that write |

## Verification
A wrong tap index, or a misaligned valid shift in the fetch path, shows at the ports within the first run. Results land at the wrong address, or carry a neighbour's operands, and appear on the writeback port within NSTAGE clocks of the affected fetch. Losing the end marker or miscounting the drain shows as busy never falling, or as words past the end being executed, which a later peek reveals. Timing-sensitive faults are exposed by the deliberate short-spacing program, which must return the stale value at one spacing and the fresh value at the next.

// File: rtl/mmseq_pkg.sv
package mmseq_pkg;
  localparam int INSTR_W = 32;
  localparam int FIELD_W = 7;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = FIELD_W;
  localparam int DEPTH   = 1 << ADDR_W;

  localparam logic [3:0] OPC_NOP = 4'd0;
  localparam logic [3:0] OPC_ADD = 4'd1;
  localparam logic [3:0] OPC_SUB = 4'd2;
  localparam logic [3:0] OPC_MPY = 4'd3;
  localparam logic [3:0] OPC_MAC = 4'd4;
  localparam logic [3:0] OPC_END = 4'd15;

  localparam logic [DATA_W-1:0] Q_ONE     = 32'h0001_0000;
  localparam logic [DATA_W-1:0] Q_NEG_ONE = 32'hFFFF_0000;

  typedef struct packed {
    logic [3:0]         op;
    logic [FIELD_W-1:0] dst;
    logic [FIELD_W-1:0] src_a;
    logic [FIELD_W-1:0] src_b;
    logic [FIELD_W-1:0] src_c;
  } instr_t;

  function automatic logic is_arith(input logic [3:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_MPY) || (op == OPC_MAC);
  endfunction
endpackage

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int RD_PORTS = 4,
  parameter int RD_LAT   = 2
) (
  input  logic                             clk,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                waddr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0]  raddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] q [RD_LAT];
    always_ff @(posedge clk) begin
      q[0] <= mem[raddr[p]];
      for (int k = 1; k < RD_LAT; k++) q[k] <= q[k-1];
    end
    assign rdata[p] = q[RD_LAT-1];
  end
endmodule

// File: rtl/mm_madd.sv
module mm_madd #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [PROD_W-1:0] MAXV =
    {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MINV = ~MAXV;

  function automatic logic [DATA_W-1:0] finish(
    input logic signed [PROD_W-1:0] prod,
    input logic [DATA_W-1:0]        addend
  );
    logic signed [PROD_W-1:0] s;
    s = (prod >>> FRAC_W) + $signed({{DATA_W{addend[DATA_W-1]}}, addend});
    if (s > MAXV)      return MAXV[DATA_W-1:0];
    else if (s < MINV) return MINV[DATA_W-1:0];
    else               return s[DATA_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] prod_now;
  assign prod_now = PROD_W'($signed(a_i)) * PROD_W'($signed(x_i));

  if (DEPTH == 1) begin : g_single
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk) r_q <= finish(prod_now, b_i);
    assign y_o = r_q;
  end else begin : g_multi
    logic signed [PROD_W-1:0] p_q;
    logic [DATA_W-1:0]        c_q;
    logic [DATA_W-1:0]        r_q [DEPTH-1];
    always_ff @(posedge clk) begin
      p_q    <= prod_now;
      c_q    <= b_i;
      r_q[0] <= finish(p_q, c_q);
      for (int k = 1; k < DEPTH - 1; k++) r_q[k] <= r_q[k-1];
    end
    assign y_o = r_q[DEPTH-2];
  end
endmodule

// File: rtl/mm_fetch.sv
module mm_fetch
  import mmseq_pkg::*;
#(
  parameter int RD_LAT = 2,
  parameter int NSTAGE = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic               run_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               ok_o,
  output logic               end_o,
  output instr_t             instr_o
);
  localparam int CNT_W = $clog2(NSTAGE + 1);

  logic [ADDR_W-1:0] pc_q;
  logic              run_q;
  logic [RD_LAT-1:0] vld_q;
  logic              done_q;
  logic [CNT_W-1:0]  drain_q;
  logic              launch;

  assign ok_o    = vld_q[RD_LAT-1];
  assign instr_o = ok_o ? instr_t'(word_i) : '0;
  assign end_o   = ok_o && (instr_o.op == OPC_END);
  assign busy_o  = run_q || (drain_q != '0);
  assign launch  = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      run_q   <= 1'b0;
      vld_q   <= '0;
      done_q  <= 1'b0;
      drain_q <= '0;
    end else if (launch) begin
      pc_q    <= '0;
      run_q   <= 1'b1;
      vld_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (run_q) pc_q <= pc_q + 1'b1;
      vld_q <= RD_LAT'({vld_q, run_q});
      if (end_o) begin
        run_q   <= 1'b0;
        vld_q   <= '0;
        drain_q <= CNT_W'(NSTAGE);
      end else if (drain_q != '0) begin
        drain_q <= drain_q - 1'b1;
        if (drain_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign pc_o   = pc_q;
  assign run_o  = run_q;
  assign done_o = done_q;
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mmseq_pkg::*;
#(
  parameter int RD_LAT     = 2,
  parameter int MADD_DEPTH = 3,
  parameter int FRAC_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_we,
  input  logic [6:0]        load_addr,
  input  logic [31:0]       load_data,
  input  logic [6:0]        peek_addr,
  output logic [31:0]       peek_data,
  output logic              busy,
  output logic              done,
  output logic              wb_valid,
  output logic [6:0]        wb_addr,
  output logic [31:0]       wb_data
);
  localparam int NSTAGE = RD_LAT + MADD_DEPTH;
  localparam int ISS    = RD_LAT - 1;
  localparam int WB     = NSTAGE - 1;
  localparam int NPORT  = 4;

  logic [NPORT-1:0][ADDR_W-1:0] rd_addr;
  logic [NPORT-1:0][DATA_W-1:0] rd_data;
  logic                         ram_we;
  logic [ADDR_W-1:0]            ram_waddr;
  logic [DATA_W-1:0]            ram_wdata;

  logic [ADDR_W-1:0] fe_pc;
  logic              fe_run, fe_ok, fe_end;
  instr_t            fe_instr;

  mm_fetch #(.RD_LAT(RD_LAT), .NSTAGE(NSTAGE)) i_fetch (
    .clk(clk), .rst(rst), .start_i(start), .word_i(rd_data[0]),
    .pc_o(fe_pc), .run_o(fe_run), .busy_o(busy), .done_o(done),
    .ok_o(fe_ok), .end_o(fe_end), .instr_o(fe_instr)
  );

  // Instruction pipeline: entry 0 takes the freshly fetched (or nop) word.
  instr_t pipe_q [NSTAGE];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSTAGE; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= fe_instr;
      for (int k = 1; k < NSTAGE; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  // Read issue: instruction port shared with the peek path when idle.
  assign rd_addr[0] = fe_run ? fe_pc : peek_addr;
  assign rd_addr[1] = fe_instr.src_a;
  assign rd_addr[2] = fe_instr.src_b;
  assign rd_addr[3] = fe_instr.src_c;

  // Operand routing into the single a*x+b unit.
  instr_t            at_iss;
  logic [DATA_W-1:0] op_a, op_x, op_b, madd_y;
  assign at_iss = pipe_q[ISS];

  always_comb begin
    op_a = '0;
    op_x = '0;
    op_b = '0;
    case (at_iss.op)
      OPC_ADD: begin op_a = Q_ONE;      op_x = rd_data[1]; op_b = rd_data[2]; end
      OPC_SUB: begin op_a = Q_NEG_ONE;  op_x = rd_data[2]; op_b = rd_data[1]; end
      OPC_MPY: begin op_a = rd_data[1]; op_x = rd_data[2]; op_b = '0;         end
      OPC_MAC: begin op_a = rd_data[1]; op_x = rd_data[2]; op_b = rd_data[3]; end
      default: ;
    endcase
  end

  mm_madd #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .DEPTH(MADD_DEPTH)) i_madd (
    .clk(clk), .a_i(op_a), .x_i(op_x), .b_i(op_b), .y_o(madd_y)
  );

  // Writeback tap and memory write arbitration.
  instr_t at_wb;
  logic   wb_we;
  assign at_wb = pipe_q[WB];
  assign wb_we = is_arith(at_wb.op);

  always_comb begin
    if (busy) begin
      ram_we    = wb_we;
      ram_waddr = at_wb.dst;
      ram_wdata = madd_y;
    end else begin
      ram_we    = load_we;
      ram_waddr = load_addr;
      ram_wdata = load_data;
    end
  end

  mm_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_PORTS(NPORT), .RD_LAT(RD_LAT)) i_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= busy && wb_we;
      wb_addr  <= at_wb.dst;
      wb_data  <= madd_y;
    end
  end

  assign peek_data = rd_data[0];
endmodule

// File: rtl/mm_seq_chk.sv
module mm_seq_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] pc,
  input logic              run,
  input logic              hit_end,
  input logic              fetch_ok
);
  AST_START_CLEARS_PC: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (pc == '0 && busy && !done)); // R3

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (run && !hit_end) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R3

  AST_END_HALTS: assert property (@(posedge clk) disable iff (rst)
    hit_end |=> !run); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_NO_FETCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fetch_ok); // R7

  AST_WB_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(busy)); // R9
endmodule

bind mm_seq mm_seq_chk #(.ADDR_W(7)) i_mm_seq_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .wb_valid(wb_valid), .pc(fe_pc), .run(fe_run), .hit_end(fe_end),
  .fetch_ok(fe_ok)
);

// File: tb/test_mm_seq.sv
`timescale 1ns/1ps
module test_mm_seq;
  localparam int RD_LAT = 2;
  localparam int MDEP   = 3;
  localparam int NST    = RD_LAT + MDEP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic load_we = 1'b0;
  logic [6:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [6:0] peek_addr = '0;
  logic [31:0] peek_data;
  logic busy, done, wb_valid;
  logic [6:0] wb_addr;
  logic [31:0] wb_data;

  always #10 clk = ~clk;

  mm_seq #(.RD_LAT(RD_LAT), .MADD_DEPTH(MDEP), .FRAC_W(16)) i_mm_seq (
    .clk(clk), .rst(rst), .start(start), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .busy(busy), .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] model [128];
  logic [31:0] prog [64];
  int plen;
  int wb_count;
  logic [6:0] wb_first_addr;
  logic [31:0] wb_first_data;

  always @(negedge clk) begin
    if (wb_valid) begin
      if (wb_count == 0) begin
        wb_first_addr = wb_addr;
        wb_first_data = wb_data;
      end
      wb_count++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] madd_ref(input logic [31:0] a, x, b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(x));
    p = p >>> 16;
    p = p + longint'($signed(b));
    if (p > 64'sd2147483647) p = 64'sd2147483647;
    if (p < -64'sd2147483648) p = -64'sd2147483648;
    return p[31:0];
  endfunction

  function automatic logic [31:0] op_ref(input logic [3:0] op, input logic [31:0] va, vb, vc);
    case (op)
      4'd1:    return madd_ref(32'h0001_0000, va, vb);
      4'd2:    return madd_ref(32'hFFFF_0000, vb, va);
      4'd3:    return madd_ref(va, vb, 32'd0);
      default: return madd_ref(va, vb, vc);
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [6:0] d, a, b, c);
    return {op, d, a, b, c};
  endfunction

  task automatic write_word(input logic [6:0] addr, input logic [31:0] data);
    @(negedge clk);
    load_we = 1'b1; load_addr = addr; load_data = data;
    @(negedge clk);
    load_we = 1'b0;
    model[addr] = data;
  endtask

  task automatic peek(input logic [6:0] addr, output logic [31:0] data);
    @(negedge clk);
    peek_addr = addr;
    repeat (RD_LAT) @(posedge clk);
    @(negedge clk);
    data = peek_data;
  endtask

  task automatic emit(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic load_prog();
    for (int i = 0; i < plen; i++) write_word(7'(i), prog[i]);
  endtask

  task automatic model_exec();
    for (int i = 0; i < plen; i++) begin
      logic [31:0] w;
      w = prog[i];
      if (w[31:28] == 4'd15) break;
      if (w[31:28] >= 4'd1 && w[31:28] <= 4'd4)
        model[w[27:21]] = op_ref(w[31:28], model[w[20:14]], model[w[13:7]], model[w[6:0]]);
    end
  endtask

  task automatic run(input bit try_load);
    int cyc;
    wb_count = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", 32'(busy), 32'd1);
    chk("R3 done cleared by start", 32'(done), 32'd0);
    if (try_load) begin
      load_we = 1'b1; load_addr = 7'd86; load_data = 32'hDEAD_BEEF;
      @(negedge clk);
      load_we = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R7 done reached", 32'(done), 32'd1);
    chk("R7 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_word(input string tag, input logic [6:0] addr, input logic [31:0] exp);
    logic [31:0] got;
    peek(addr, got);
    chk(tag, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog expired: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 wb_valid", 32'(wb_valid), 32'd0);

    // R2: load and peek while idle
    for (int i = 0; i < 3; i++) begin
      logic [31:0] v;
      v = $urandom;
      write_word(7'(120 + i), v);
      expect_word("R2 load/peek", 7'(120 + i), v);
    end

    // R4/R5/R11/R9: directed arithmetic, back to back
    write_word(7'd100, 32'h0001_8000);
    write_word(7'd101, 32'h0002_4000);
    write_word(7'd102, 32'h00C8_0000);
    write_word(7'd103, 32'h012C_0000);
    write_word(7'd104, 32'hFFFE_8000);
    write_word(7'd105, 32'h0000_0001);
    write_word(7'd106, 32'h000A_0000);
    write_word(7'd107, 32'h8AD0_0000);
    write_word(7'd108, 32'h2710_0000);
    plen = 0;
    emit(mk(4'd1, 7'd112, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd2, 7'd113, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd3, 7'd114, 7'd102, 7'd103, 7'd0));
    emit(mk(4'd3, 7'd115, 7'd104, 7'd105, 7'd0));
    emit(mk(4'd4, 7'd116, 7'd100, 7'd101, 7'd106));
    emit(mk(4'd2, 7'd117, 7'd107, 7'd108, 7'd0));
    emit(mk(4'd15, 7'd0, 7'd0, 7'd0, 7'd0));
    load_prog();
    run(1'b0);
    model_exec();
    expect_word("R5 add", 7'd112, 32'h0003_C000);
    expect_word("R5 sub", 7'd113, 32'hFFFF_4000);
    expect_word("R5 mpy saturate high", 7'd114, 32'h7FFF_FFFF);
    expect_word("R5 mpy floor truncation", 7'd115, 32'hFFFF_FFFE);
    expect_word("R5 mpy_add", 7'd116, 32'h000D_6000);
    expect_word("R5 sub saturate low", 7'd117, 32'h8000_0000);
    chk("R9 write count", 32'(wb_count), 32'd6);
    chk("R9 first wb addr", 32'(wb_first_addr), 32'd112);
    chk("R9 first wb data", wb_first_data, 32'h0003_C000);

    // R6: non-arithmetic opcodes write nothing
    for (int i = 90; i < 95; i++) write_word(7'(i), 32'h5A5A_0000 + 32'(i));
    plen = 0;
    emit(mk(4'd0, 7'd90, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd5, 7'd91, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd9, 7'd92, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd14, 7'd93, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd1, 7'd94, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd15, 7'd0, 7'd0, 7'd0, 7'd0));
    load_prog();
    run(1'b0);
    model_exec();
    for (int i = 90; i < 94; i++)
      expect_word("R6 untouched by non-arith opcode", 7'(i), 32'h5A5A_0000 + 32'(i));
    expect_word("R6 arith still writes", 7'd94, 32'h0003_C000);
    chk("R6 single writeback", 32'(wb_count), 32'd1);

    // R7: words after end never run
    write_word(7'd96, 32'h1111_1111);
    write_word(7'd97, 32'h2222_2222);
    plen = 0;
    emit(mk(4'd1, 7'd95, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd15, 7'd0, 7'd0, 7'd0, 7'd0));
    emit(mk(4'd1, 7'd96, 7'd100, 7'd101, 7'd0));
    emit(mk(4'd3, 7'd97, 7'd100, 7'd101, 7'd0));
    load_prog();
    run(1'b0);
    expect_word("R7 before end runs", 7'd95, 32'h0003_C000);
    expect_word("R7 after end skipped", 7'd96, 32'h1111_1111);
    expect_word("R7 after end skipped", 7'd97, 32'h2222_2222);
    chk("R7 writes before end only", 32'(wb_count), 32'd1);

    // R8: no interlock; R10: load ignored while busy
    write_word(7'd80, 32'h0001_0000);
    write_word(7'd82, 32'h0007_0000);
    write_word(7'd84, 32'h0000_0000);
    write_word(7'd86, 32'h0000_1234);
    plen = 0;
    emit(mk(4'd1, 7'd82, 7'd80, 7'd80, 7'd0));
    for (int i = 0; i < NST - 1; i++) emit(32'd0);
    emit(mk(4'd1, 7'd83, 7'd82, 7'd84, 7'd0));
    emit(mk(4'd1, 7'd85, 7'd82, 7'd84, 7'd0));
    emit(mk(4'd15, 7'd0, 7'd0, 7'd0, 7'd0));
    load_prog();
    run(1'b1);
    expect_word("R8 producer result", 7'd82, 32'h0002_0000);
    expect_word("R8 consumer too close sees old", 7'd83, 32'h0007_0000);
    expect_word("R8 consumer far enough sees new", 7'd85, 32'h0002_0000);
    expect_word("R10 load while busy ignored", 7'd86, 32'h0000_1234);

    // R11/R5: random independent back-to-back instructions
    for (int r = 0; r < 6; r++) begin
      for (int i = 64; i < 96; i++) begin
        logic [31:0] v;
        v = $urandom;
        if (($urandom % 2) == 0) v = {{13{v[18]}}, v[18:0]};
        write_word(7'(i), v);
      end
      plen = 0;
      for (int k = 0; k < 16; k++)
        emit(mk(4'($urandom_range(1, 4)), 7'(96 + k), 7'($urandom_range(64, 95)),
                7'($urandom_range(64, 95)), 7'($urandom_range(64, 95))));
      emit(mk(4'd15, 7'd0, 7'd0, 7'd0, 7'd0));
      load_prog();
      run(1'b0);
      model_exec();
      for (int k = 0; k < 16; k++) expect_word("R11 random result", 7'(96 + k), model[96 + k]);
      chk("R9 random write count", 32'(wb_count), 32'd16);
    end

    // R8/R5: bank of four first-order filters, several iterations
    write_word(7'd64, 32'h0000_8000);
    for (int i = 0; i < 4; i++) begin
      write_word(7'(68 + i), 32'd0);
      write_word(7'(72 + i), 32'(3277 * (i + 1)));
    end
    plen = 0;
    for (int i = 0; i < 4; i++) emit(mk(4'd2, 7'(76 + i), 7'd64, 7'(68 + i), 7'd0));
    for (int i = 4; i < NST + 1; i++) emit(32'd0);
    for (int i = 0; i < 4; i++) emit(mk(4'd4, 7'(68 + i), 7'(76 + i), 7'(72 + i), 7'(68 + i)));
    emit(mk(4'd15, 7'd0, 7'd0, 7'd0, 7'd0));
    load_prog();
    for (int it = 0; it < 6; it++) begin
      run(1'b0);
      model_exec();
      for (int i = 0; i < 4; i++) expect_word("R8 filter output", 7'(68 + i), model[68 + i]);
    end

    peek(7'd68, got);
    chk("R5 filter moved toward input", 32'(got != 32'd0), 32'd1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule